// File: doc/BRIEF.md
# Framed Serial Transmitter with Fractional Bit Timing

This block serialises one byte at a time onto an asynchronous serial line. Software loads a packed line-control word, a 16-bit integer divisor and a 3-bit fractional adder through a simple write strobe, then writes a byte to the holding register. The block builds the whole frame and shifts it out least significant bit first. The frame is a low start bit, 5 to 8 data bits, an optional parity bit, and one or two high stop bits. Each bit lasts 16·divisor + fraction + 16 reference clocks.

A zero divisor stops any frame from starting. Two status bits, transmitter-empty and buffer-empty, drop when a byte is accepted and return when its last stop bit ends. In the same cycle a one-cycle transmit event pulse is raised, which an interrupt controller can latch. Framing and timing are captured when a frame starts, so software may program the next frame's settings while the current one is still on the line.

Top module: `ser_tx`

## Requirements
- R1: After reset the line is high, the status output reads 3'b110 (bit 2 transmitter empty, bit 1 buffer empty, bit 0 always 0) and the event output is low.
- R2: The write address selects a register: 0 line control, 1 divisor, 2 fraction, 3 holding. An accepted byte is sent as a low start bit and then line-control bits [1:0] + 5 data bits, least significant bit first. The line is high whenever the transmitter is empty.
- R3: Line-control bit 2 set gives two high stop bits; clear gives one.
- R4: Line-control bit 5 set inserts a parity bit after the data. Line-control bit 3 set makes it even parity (data ones plus parity bit is even); clear makes it odd parity.
- R5: Every bit lasts exactly 16·divisor + fraction + 16 clock cycles. Only write-data bits [2:0] are kept as the fraction.
- R6: While the divisor register is zero, a holding-register write is ignored: the line stays high and the status stays 3'b110.
- R7: An accepted holding write clears both empty bits from the next cycle. Both are set again in the cycle after the last stop bit ends.
- R8: The event output is high for exactly one cycle, the same cycle in which the empty bits return.
- R9: A holding-register write while a frame is in progress is ignored. The current frame is unchanged and no further frame follows.
- R10: Line-control and divisor writes made during a frame do not alter that frame. They take effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (0 line control, 1 divisor, 2 fraction, 3 holding) |
| wr_data_i | input | DIV_W | Write data |
| txd_o | output | 1 | Serial line, idles high |
| status_o | output | 3 | {transmitter empty, buffer empty, 0} |
| tx_done_o | output | 1 | One-cycle pulse when a frame completes |

## Verification
The strobe edge that accepts a holding write is counted as cycle 0. From there the start bit and the cleared status are visible in cycle 0, bit k occupies cycles k·T to (k+1)·T−1, and the restored status and event pulse appear in cycle F·T, where F is the frame length. The bench steps one cycle at a time from that edge. It samples each bit at the middle of its slot and both sides of the first bit boundary, checks the status one cycle before and at F·T, and checks that the event has fallen at F·T+1. Writes that must be ignored are made in a known cycle inside the frame, and the line and status are then followed to the end of the frame and beyond.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  localparam logic [1:0] ADDR_LINE = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_FRAC = 2'd2;
  localparam logic [1:0] ADDR_HOLD = 2'd3;

  localparam int MAX_FRAME = 12;  // start + 8 data + parity + 2 stop
  localparam int LEFT_W    = $clog2(MAX_FRAME + 1);

  typedef struct packed {
    logic       par_en;
    logic       par_even;
    logic       stop2;
    logic [1:0] len;
  } line_cfg_t;

  function automatic logic [LEFT_W-1:0] frame_bits(input line_cfg_t c);
    return LEFT_W'(7) + LEFT_W'(c.len) + LEFT_W'(c.par_en) + LEFT_W'(c.stop2);
  endfunction

endpackage

// File: rtl/ser_tx_cfg.sv
module ser_tx_cfg
  import ser_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DIV_W-1:0]  wr_data_i,
  output line_cfg_t         line_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              hold_wr_o,
  output logic [7:0]        hold_data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o <= '0;
      div_o  <= '0;
      frac_o <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_LINE: line_o <= '{par_en:   wr_data_i[5],
                               par_even: wr_data_i[3],
                               stop2:    wr_data_i[2],
                               len:      wr_data_i[1:0]};
        ADDR_DIV:  div_o  <= wr_data_i;
        ADDR_FRAC: frac_o <= wr_data_i[FRAC_W-1:0];
        default:   ;
      endcase
    end
  end

  assign hold_wr_o   = wr_en_i && (wr_addr_i == ADDR_HOLD);
  assign hold_data_o = wr_data_i[7:0];

endmodule

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  parameter int CNT_W  = DIV_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt_q;

  assign period = CNT_W'({div_i, 4'b0000}) + CNT_W'(frac_i) + CNT_W'(16);
  assign tick_o = run_i && (cnt_q == period - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end

  // bit period is never shorter than 16 cycles
  assert_tick_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame
  import ser_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_wr_i,
  input  logic [7:0]        hold_data_i,
  input  line_cfg_t         line_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic [DIV_W-1:0]  div_q_o,
  output logic [FRAC_W-1:0] frac_q_o,
  output logic              txd_o,
  output logic              tx_empty_o,
  output logic              buf_empty_o,
  output logic              done_o
);

  logic                 busy_q;
  logic [MAX_FRAME-1:0] shreg_q;
  logic [MAX_FRAME-1:0] frame_c;
  logic [LEFT_W-1:0]    left_q;
  logic [7:0]           data_mask;
  logic                 par_bit;
  logic                 start;

  assign start     = hold_wr_i && !busy_q && (div_i != '0);
  assign data_mask = 8'hFF >> (2'd3 - line_i.len);
  assign par_bit   = line_i.par_even ? ^(hold_data_i & data_mask)
                                     : ~^(hold_data_i & data_mask);

  always_comb begin
    frame_c    = '1;
    frame_c[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 5 + int'(line_i.len)) frame_c[i+1] = hold_data_i[i];
    end
    for (int j = 6; j < MAX_FRAME; j++) begin
      if (line_i.par_en && (j == 6 + int'(line_i.len))) frame_c[j] = par_bit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      shreg_q     <= '1;
      left_q      <= '0;
      div_q_o     <= '0;
      frac_q_o    <= '0;
      tx_empty_o  <= 1'b1;
      buf_empty_o <= 1'b1;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        busy_q      <= 1'b1;
        shreg_q     <= frame_c;
        left_q      <= frame_bits(line_i);
        div_q_o     <= div_i;
        frac_q_o    <= frac_i;
        tx_empty_o  <= 1'b0;
        buf_empty_o <= 1'b0;
      end else if (busy_q && tick_i) begin
        if (left_q == LEFT_W'(1)) begin
          busy_q      <= 1'b0;
          shreg_q     <= '1;
          left_q      <= '0;
          tx_empty_o  <= 1'b1;
          buf_empty_o <= 1'b1;
          done_o      <= 1'b1;
        end else begin
          shreg_q <= {1'b1, shreg_q[MAX_FRAME-1:1]};
          left_q  <= left_q - LEFT_W'(1);
        end
      end
    end
  end

  assign txd_o = shreg_q[0];
  assign run_o = busy_q;

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (!txd_o && !tx_empty_o && !buf_empty_o));
  assert_idle_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o);
  assert_done_restores_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tx_empty_o && buf_empty_o && $past(busy_q)));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_wr_i && busy_q && !tick_i) |=> ($stable(left_q) && $stable(shreg_q)));
  assert_snapshot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start) |=> ($stable(div_q_o) && $stable(frac_q_o)));

endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [DIV_W-1:0] wr_data_i,
  output logic             txd_o,
  output logic [2:0]       status_o,
  output logic             tx_done_o
);

  localparam int CNT_W = DIV_W + 5;

  line_cfg_t         line_cfg;
  logic [DIV_W-1:0]  div_reg, div_q;
  logic [FRAC_W-1:0] frac_reg, frac_q;
  logic              hold_wr, run, tick, tx_empty, buf_empty;
  logic [7:0]        hold_data;

  ser_tx_cfg #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .line_o(line_cfg), .div_o(div_reg), .frac_o(frac_reg),
    .hold_wr_o(hold_wr), .hold_data_o(hold_data)
  );

  ser_tx_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_baud (
    .clk_i, .rst_ni, .run_i(run), .div_i(div_q), .frac_i(frac_q), .tick_o(tick)
  );

  ser_tx_frame #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_frame (
    .clk_i, .rst_ni, .hold_wr_i(hold_wr), .hold_data_i(hold_data),
    .line_i(line_cfg), .div_i(div_reg), .frac_i(frac_reg), .tick_i(tick),
    .run_o(run), .div_q_o(div_q), .frac_q_o(frac_q), .txd_o,
    .tx_empty_o(tx_empty), .buf_empty_o(buf_empty), .done_o(tx_done_o)
  );

  assign status_o = {tx_empty, buf_empty, 1'b0};

  assert_div_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_wr && div_reg == '0 && tx_empty) |=> (tx_empty && txd_o));
  assert_status_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty) |-> (buf_empty && tx_done_o));

endmodule

// File: tb/sim_ser_tx.sv
module sim_ser_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        txd, done;
  logic [2:0]  status;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ser_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .txd_o(txd), .status_o(status), .tx_done_o(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mode: 0 none, 1 holding write mid-frame, 2 divisor write, 3 line write
  task automatic run_frame(input logic [7:0] d, input logic [7:0] lcr, input int dv,
                           input int fr_wr, input bit prog, input int mode,
                           input string tag);
    logic [11:0] e;
    int nb, len, t, f;
    bit p;
    t = 16 * dv + (fr_wr & 7) + 16;
    len = 5 + int'(lcr[1:0]);
    e = '1; e[0] = 1'b0; nb = 1; p = 1'b0;
    for (int i = 0; i < len; i++) begin e[nb] = d[i]; p ^= d[i]; nb++; end
    if (lcr[5]) begin e[nb] = lcr[3] ? p : ~p; nb++; end
    nb++;
    if (lcr[2]) nb++;
    f = nb;
    if (prog) begin
      wr(2'd0, {8'h00, lcr});
      wr(2'd1, 16'(dv));
      wr(2'd2, 16'(fr_wr));
    end
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = {8'h00, d};
    @(negedge clk);
    wr_en = 1'b0;
    for (int c = 0; c <= f * t + 1; c++) begin
      if (c == 0) check(status == 3'b000, "R7 status cleared", status, 0);
      if (c % t == t / 2 && c / t < f)
        check(txd == e[c / t], tag, txd, e[c / t]);
      if (c == t - 1) check(txd == 1'b0, "R5 start spans T", txd, 0);
      if (c == t) check(txd == e[1], "R5 first data at T", txd, e[1]);
      if (c == f * t - 1) begin
        check(status == 3'b000, "R7 busy until end", status, 0);
        check(done == 1'b0, "R8 no early event", done, 0);
      end
      if (c == f * t) begin
        check(status == 3'b110, "R7 status restored", status, 6);
        check(done == 1'b1, "R8 event at end", done, 1);
        check(txd == 1'b1, "R2 idle after frame", txd, 1);
      end
      if (c == f * t + 1) check(done == 1'b0, "R8 single pulse", done, 0);
      if (c == t + 1 && mode != 0) begin
        wr_en = 1'b1;
        case (mode)
          1: begin wr_addr = 2'd3; wr_data = {8'h00, ~d}; end
          2: begin wr_addr = 2'd1; wr_data = 16'd3; end
          default: begin wr_addr = 2'd0; wr_data = {8'h00, lcr ^ 8'h27}; end
        endcase
      end
      if (c == t + 2) wr_en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(txd == 1'b1, "R1 line high", txd, 1);
    check(status == 3'b110, "R1 status", status, 6);
    check(done == 1'b0, "R1 event low", done, 0);
  endtask

  task automatic t_basic();
    run_frame(8'hA5, 8'h03, 1, 0, 1'b1, 0, "R2 8N1 bit");
    run_frame(8'h3C, 8'h03, 1, 0, 1'b1, 0, "R2 8N1 second pattern");
  endtask

  task automatic t_parity_stop();
    run_frame(8'h0B, 8'h28, 1, 0, 1'b1, 0, "R4 5-bit even parity");
    run_frame(8'h4D, 8'h26, 1, 0, 1'b1, 0, "R4 R3 7-bit odd parity two stop");
    run_frame(8'hF1, 8'h05, 1, 0, 1'b1, 0, "R3 6-bit two stop");
  endtask

  task automatic t_timing();
    run_frame(8'h81, 8'h03, 1, 15, 1'b1, 0, "R5 frac upper bits dropped");
    run_frame(8'h55, 8'h2B, 2, 3, 1'b1, 0, "R5 div 2 frac 3");
  endtask

  task automatic t_div_zero();
    wr(2'd1, 16'd0);
    wr(2'd3, 16'h0055);
    for (int c = 0; c < 40; c++) begin
      if (txd != 1'b1 || status != 3'b110) begin
        check(1'b0, "R6 write with zero divisor", {status, txd}, 4'hD);
        return;
      end
      @(negedge clk);
    end
    check(1'b1, "R6 write with zero divisor", 0, 0);
  endtask

  task automatic t_busy();
    run_frame(8'h96, 8'h03, 1, 0, 1'b1, 1, "R9 frame kept");
    for (int c = 0; c < 100; c++) begin
      if (txd != 1'b1 || status != 3'b110) begin
        check(1'b0, "R9 no second frame", {status, txd}, 4'hD);
        return;
      end
      @(negedge clk);
    end
    check(1'b1, "R9 no second frame", 0, 0);
  endtask

  task automatic t_latch();
    run_frame(8'hC3, 8'h03, 1, 0, 1'b1, 2, "R10 divisor write mid-frame");
    run_frame(8'hC3, 8'h03, 3, 0, 1'b0, 0, "R10 new divisor next frame");
    run_frame(8'h5A, 8'h03, 1, 0, 1'b1, 3, "R10 line write mid-frame");
    run_frame(8'h5A, 8'h24, 1, 0, 1'b0, 0, "R10 new line next frame");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_parity_stop();
    t_timing();
    t_div_zero();
    t_busy();
    t_latch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule